// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer in which every entry covers two neighbouring virtual pages, one even and one odd, each pointing at its own physical frame. A per-entry page mask widens the pair from the 4 KB base page up to larger sizes. The entry also carries an address-space tag, a global flag that makes the tag irrelevant, and a hardware-invalidate flag that removes the entry from matching. Each page of the pair has its own valid, dirty, read-inhibit and execute-inhibit bits.

A lookup presents a virtual address, an access kind and the current address-space tag. All entries are compared at once. One clock later the block returns a result code, the physical address, and read and write permission. Software or a refill engine loads entries one at a time through a write port, by index.

Top module: `pptlb_lookup`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_read_ok` and `rsp_write_ok` are 0, `rsp_paddr` is 0 and `rsp_code` is NOMATCH (-2). Every entry starts with its invalidate flag set, so any lookup before the first write returns NOMATCH.
- R2: An entry hits only when three things hold:
  - its invalidate flag is clear;
  - its global bit is set or its address-space tag equals `req_asid`;
  - its VPN equals `req_vaddr` once the effective-mask bits are cleared from both.
- R3: The effective mask is the entry page mask ORed with 0x1FFF, the offset span of two 4 KB pages. The odd page is selected when `req_vaddr` has a 1 in the highest set bit of the effective mask.
- R4: On MATCH, `rsp_paddr` is the selected page's frame address ORed with `req_vaddr` AND (effective mask >> 1).
- R5: On a hit, the result is decided by the first of these checks that applies to the selected page:
  - its valid bit is clear: INVALID (-3);
  - the access is a fetch and execute-inhibit is set: XI (-6);
  - the access is a load and read-inhibit is set: RI (-5);
  - the access is a store and dirty is clear: DIRTY (-4);
  - none of the above: MATCH (0).
  The access kind is 0 for fetch, 1 for load and 2 for store. Page flags are bit 0 valid, bit 1 dirty, bit 2 read-inhibit and bit 3 execute-inhibit.
- R6: `rsp_read_ok` is 1 exactly when the result is MATCH. `rsp_write_ok` is 1 only on MATCH with the selected page's dirty bit set.
- R7: When several entries hit, the entry with the lowest index decides the result.
- R8: `rsp_valid` is 1 in the cycle after `req_valid` and 0 otherwise. Without a request, all other outputs hold their values.
- R9: A write with `wr_en` replaces entry `wr_idx` at the clock edge. A lookup presented in the same cycle sees the entry as it was before the write.
- R10: When no entry hits, the result is NOMATCH (-2), `rsp_paddr` is 0 and both permissions are 0. BADADDR (-1) is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | AW | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_asid | input | ASID_W | Current address-space tag |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | AW | Virtual page-pair address of the entry |
| wr_pmask | input | AW | Page mask, ones above bit 12 widen the page |
| wr_asid | input | ASID_W | Address-space tag of the entry |
| wr_global | input | 1 | Entry matches every address space |
| wr_hinv | input | 1 | Entry invalidated, never matches |
| wr_pfn_even | input | AW | Frame address of the even page |
| wr_pfn_odd | input | AW | Frame address of the odd page |
| wr_flags_even | input | 4 | Even page flags {xi, ri, dirty, valid} |
| wr_flags_odd | input | 4 | Odd page flags {xi, ri, dirty, valid} |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_paddr | output | AW | Physical address |
| rsp_read_ok | output | 1 | Read permitted |
| rsp_write_ok | output | 1 | Write permitted |
| rsp_code | output | 4 | Signed result code |

## Verification
The entry array cannot be observed directly, so any corrupted field surfaces as a wrong result code or physical address. This happens on the first lookup that reaches that entry, one cycle after the request. A stale invalidate or valid bit shows up as NOMATCH or INVALID where a match is expected. A flipped page-select bit gives the other frame's address, and a broken priority shows up as a higher-index entry's frame. The bench therefore places overlapping entries, mixed page sizes and every flag combination behind lookups. It also compares each cycle's outputs, including idle cycles, against a behavioural model.

// File: rtl/pptlb_pkg.sv
package pptlb_pkg;
    localparam logic signed [3:0] RC_MATCH   = 4'sd0;
    localparam logic signed [3:0] RC_BADADDR = -4'sd1;
    localparam logic signed [3:0] RC_NOMATCH = -4'sd2;
    localparam logic signed [3:0] RC_INVALID = -4'sd3;
    localparam logic signed [3:0] RC_DIRTY   = -4'sd4;
    localparam logic signed [3:0] RC_RI      = -4'sd5;
    localparam logic signed [3:0] RC_XI      = -4'sd6;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam int FL_V  = 0;
    localparam int FL_D  = 1;
    localparam int FL_RI = 2;
    localparam int FL_XI = 3;
endpackage

// File: rtl/pptlb_store.sv
module pptlb_store #(
    parameter int ENTRIES = 16,
    parameter int AW      = 32,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [AW-1:0]     wr_vpn,
    input  logic [AW-1:0]     wr_pmask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_hinv,
    input  logic [AW-1:0]     wr_pfn_even,
    input  logic [AW-1:0]     wr_pfn_odd,
    input  logic [3:0]        wr_flags_even,
    input  logic [3:0]        wr_flags_odd,
    output logic [AW-1:0]     e_vpn   [ENTRIES],
    output logic [AW-1:0]     e_pmask [ENTRIES],
    output logic [ASID_W-1:0] e_asid  [ENTRIES],
    output logic              e_glob  [ENTRIES],
    output logic              e_hinv  [ENTRIES],
    output logic [AW-1:0]     e_pfn_e [ENTRIES],
    output logic [AW-1:0]     e_pfn_o [ENTRIES],
    output logic [3:0]        e_fl_e  [ENTRIES],
    output logic [3:0]        e_fl_o  [ENTRIES]
);
    typedef struct packed {
        logic [AW-1:0]     vpn;
        logic [AW-1:0]     pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              hinv;
        logic [AW-1:0]     pfn_e;
        logic [AW-1:0]     pfn_o;
        logic [3:0]        fl_e;
        logic [3:0]        fl_o;
    } ent_t;

    ent_t tab_d [ENTRIES];
    ent_t tab_q [ENTRIES];

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx] = '{vpn: wr_vpn, pmask: wr_pmask, asid: wr_asid,
                              glob: wr_global, hinv: wr_hinv,
                              pfn_e: wr_pfn_even, pfn_o: wr_pfn_odd,
                              fl_e: wr_flags_even, fl_o: wr_flags_odd};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i]      <= '0;
                tab_q[i].hinv <= 1'b1;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_out
        assign e_vpn[g]   = tab_q[g].vpn;
        assign e_pmask[g] = tab_q[g].pmask;
        assign e_asid[g]  = tab_q[g].asid;
        assign e_glob[g]  = tab_q[g].glob;
        assign e_hinv[g]  = tab_q[g].hinv;
        assign e_pfn_e[g] = tab_q[g].pfn_e;
        assign e_pfn_o[g] = tab_q[g].pfn_o;
        assign e_fl_e[g]  = tab_q[g].fl_e;
        assign e_fl_o[g]  = tab_q[g].fl_o;
    end
endmodule

// File: rtl/pptlb_match.sv
module pptlb_match #(
    parameter int ENTRIES    = 16,
    parameter int AW         = 32,
    parameter int ASID_W     = 8,
    parameter int BASE_SHIFT = 12,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic [AW-1:0]     va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [AW-1:0]     e_vpn   [ENTRIES],
    input  logic [AW-1:0]     e_pmask [ENTRIES],
    input  logic [ASID_W-1:0] e_asid  [ENTRIES],
    input  logic              e_glob  [ENTRIES],
    input  logic              e_hinv  [ENTRIES],
    output logic              hit_any,
    output logic [IDX_W-1:0]  hit_idx
);
    localparam logic [AW-1:0] MIN_OFF = AW'((64'd1 << (BASE_SHIFT + 1)) - 64'd1);

    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [AW-1:0] m_eff;
        logic          space_ok;
        logic          tag_ok;
        assign m_eff      = e_pmask[g] | MIN_OFF;
        assign space_ok   = e_glob[g] || (e_asid[g] == cur_asid);
        assign tag_ok     = (va & ~m_eff) == (e_vpn[g] & ~m_eff);
        assign hit_vec[g] = !e_hinv[g] && space_ok && tag_ok;
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/pptlb_check.sv
module pptlb_check
    import pptlb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BASE_SHIFT = 12
) (
    input  logic [AW-1:0]     va,
    input  logic [1:0]        kind,
    input  logic [AW-1:0]     pmask,
    input  logic [AW-1:0]     pfn_e,
    input  logic [AW-1:0]     pfn_o,
    input  logic [3:0]        fl_e,
    input  logic [3:0]        fl_o,
    output logic signed [3:0] code,
    output logic [AW-1:0]     paddr,
    output logic              rd_ok,
    output logic              wr_ok
);
    localparam logic [AW-1:0] MIN_OFF = AW'((64'd1 << (BASE_SHIFT + 1)) - 64'd1);

    logic [AW-1:0] m_eff;
    logic [AW-1:0] sel_bit;
    logic          odd;
    logic [3:0]    fl;
    logic [AW-1:0] pfn;

    assign m_eff   = pmask | MIN_OFF;
    assign sel_bit = m_eff & ~(m_eff >> 1);
    assign odd     = |(va & sel_bit);
    assign fl      = odd ? fl_o : fl_e;
    assign pfn     = odd ? pfn_o : pfn_e;

    always_comb begin
        paddr = '0;
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        if (!fl[FL_V])                                code = RC_INVALID;
        else if (kind == ACC_FETCH && fl[FL_XI])      code = RC_XI;
        else if (kind == ACC_LOAD && fl[FL_RI])       code = RC_RI;
        else if (kind == ACC_STORE && !fl[FL_D])      code = RC_DIRTY;
        else begin
            code  = RC_MATCH;
            paddr = pfn | (va & (m_eff >> 1));
            rd_ok = 1'b1;
            wr_ok = fl[FL_D];
        end
    end
endmodule

// File: rtl/pptlb_lookup.sv
module pptlb_lookup
    import pptlb_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int AW         = 32,
    parameter int ASID_W     = 8,
    parameter int BASE_SHIFT = 12,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [AW-1:0]     wr_vpn,
    input  logic [AW-1:0]     wr_pmask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_hinv,
    input  logic [AW-1:0]     wr_pfn_even,
    input  logic [AW-1:0]     wr_pfn_odd,
    input  logic [3:0]        wr_flags_even,
    input  logic [3:0]        wr_flags_odd,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic              rsp_read_ok,
    output logic              rsp_write_ok,
    output logic signed [3:0] rsp_code
);
    typedef struct packed {
        logic              vld;
        logic signed [3:0] code;
        logic [AW-1:0]     pa;
        logic              rd;
        logic              wr;
    } rsp_t;

    logic [AW-1:0]     e_vpn   [ENTRIES];
    logic [AW-1:0]     e_pmask [ENTRIES];
    logic [ASID_W-1:0] e_asid  [ENTRIES];
    logic              e_glob  [ENTRIES];
    logic              e_hinv  [ENTRIES];
    logic [AW-1:0]     e_pfn_e [ENTRIES];
    logic [AW-1:0]     e_pfn_o [ENTRIES];
    logic [3:0]        e_fl_e  [ENTRIES];
    logic [3:0]        e_fl_o  [ENTRIES];

    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic signed [3:0] chk_code;
    logic [AW-1:0]     chk_pa;
    logic              chk_rd;
    logic              chk_wr;

    rsp_t rsp_d, rsp_q;

    pptlb_store #(.ENTRIES(ENTRIES), .AW(AW), .ASID_W(ASID_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_hinv(wr_hinv),
        .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
        .wr_flags_even(wr_flags_even), .wr_flags_odd(wr_flags_odd),
        .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid), .e_glob(e_glob),
        .e_hinv(e_hinv), .e_pfn_e(e_pfn_e), .e_pfn_o(e_pfn_o),
        .e_fl_e(e_fl_e), .e_fl_o(e_fl_o)
    );

    pptlb_match #(.ENTRIES(ENTRIES), .AW(AW), .ASID_W(ASID_W),
                  .BASE_SHIFT(BASE_SHIFT)) u_match (
        .va(req_vaddr), .cur_asid(req_asid),
        .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid),
        .e_glob(e_glob), .e_hinv(e_hinv),
        .hit_any(hit_any), .hit_idx(hit_idx)
    );

    pptlb_check #(.AW(AW), .BASE_SHIFT(BASE_SHIFT)) u_check (
        .va(req_vaddr), .kind(req_kind), .pmask(e_pmask[hit_idx]),
        .pfn_e(e_pfn_e[hit_idx]), .pfn_o(e_pfn_o[hit_idx]),
        .fl_e(e_fl_e[hit_idx]), .fl_o(e_fl_o[hit_idx]),
        .code(chk_code), .paddr(chk_pa), .rd_ok(chk_rd), .wr_ok(chk_wr)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            if (hit_any) begin
                rsp_d.code = chk_code;
                rsp_d.pa   = chk_pa;
                rsp_d.rd   = chk_rd;
                rsp_d.wr   = chk_wr;
            end else begin
                rsp_d.code = RC_NOMATCH;
                rsp_d.pa   = '0;
                rsp_d.rd   = 1'b0;
                rsp_d.wr   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{vld: 1'b0, code: RC_NOMATCH, pa: '0, rd: 1'b0, wr: 1'b0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.vld;
    assign rsp_code     = rsp_q.code;
    assign rsp_paddr    = rsp_q.pa;
    assign rsp_read_ok  = rsp_q.rd;
    assign rsp_write_ok = rsp_q.wr;
endmodule

// File: rtl/pptlb_lookup_chk.sv
module pptlb_lookup_chk
    import pptlb_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              rsp_valid,
    input logic [AW-1:0]     rsp_paddr,
    input logic              rsp_read_ok,
    input logic              rsp_write_ok,
    input logic signed [3:0] rsp_code
);
    // R8: response follows a request by exactly one cycle
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: without a request nothing is reported and outputs hold
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_code) && $stable(rsp_paddr)
                        && $stable(rsp_write_ok)));

    // R6: read permission exactly on a match
    a_r6_read_iff_match: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_read_ok == (rsp_code == RC_MATCH));

    // R6: write permission only with a match
    a_r6_write_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_write_ok |-> (rsp_code == RC_MATCH));

    // R10: a miss carries no address and no permission
    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == RC_NOMATCH) |-> (rsp_paddr == '0 && !rsp_read_ok && !rsp_write_ok));

    // R10: the address-range error code never appears
    a_r10_no_badaddr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code != RC_BADADDR);

    // R5: each inhibit or dirty failure belongs to its own access kind
    a_r5_xi_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_XI) |-> $past(req_kind) == ACC_FETCH);
    a_r5_ri_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_RI) |-> $past(req_kind) == ACC_LOAD);
    a_r5_dirty_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_DIRTY) |-> $past(req_kind) == ACC_STORE);
endmodule

bind pptlb_lookup pptlb_lookup_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_read_ok(rsp_read_ok),
    .rsp_write_ok(rsp_write_ok), .rsp_code(rsp_code)
);

// File: tb/pptlb_lookup_bench.sv
`timescale 1ns/1ps
module pptlb_lookup_bench;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 0;
    logic [31:0] req_vaddr = 0;
    logic [1:0]  req_kind = 0;
    logic [7:0]  req_asid = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [31:0] wr_vpn = 0, wr_pmask = 0, wr_pfn_even = 0, wr_pfn_odd = 0;
    logic [7:0]  wr_asid = 0;
    logic        wr_global = 0, wr_hinv = 0;
    logic [3:0]  wr_flags_even = 0, wr_flags_odd = 0;
    logic        rsp_valid, rsp_read_ok, rsp_write_ok;
    logic [31:0] rsp_paddr;
    logic signed [3:0] rsp_code;

    pptlb_lookup u_pptlb_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_asid(req_asid), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_hinv(wr_hinv), .wr_pfn_even(wr_pfn_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_flags_even(wr_flags_even),
        .wr_flags_odd(wr_flags_odd), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_read_ok(rsp_read_ok), .rsp_write_ok(rsp_write_ok), .rsp_code(rsp_code)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string cur_tag = "R1";

    // behavioural model state
    logic [31:0] m_vpn [N], m_pm [N], m_pe [N], m_po [N];
    int          m_asid [N];
    bit          m_g [N], m_hinv [N];
    logic [3:0]  m_fe [N], m_fo [N];

    bit          e_vld = 0, e_rd = 0, e_wr = 0;
    int          e_code = -2;
    logic [31:0] e_pa = 0;
    string       e_tag = "R1";

    function automatic void ref_lookup(input logic [31:0] va, input int kind, input int asid,
                                       output int code, output logic [31:0] pa,
                                       output bit rd, output bit wr);
        logic [31:0] m;
        logic [3:0]  f;
        bit          odd;
        code = -2; pa = 0; rd = 0; wr = 0;
        for (int i = 0; i < N; i++) begin
            m = m_pm[i] | 32'h1FFF;
            if (!m_hinv[i] && (m_g[i] || m_asid[i] == asid) &&
                ((va & ~m) == (m_vpn[i] & ~m))) begin
                odd = (va & (m ^ (m >> 1))) != 0;
                f = odd ? m_fo[i] : m_fe[i];
                if (!f[0])                   code = -3;
                else if (kind == 0 && f[3])  code = -6;
                else if (kind == 1 && f[2])  code = -5;
                else if (kind == 2 && !f[1]) code = -4;
                else begin
                    code = 0;
                    pa = (odd ? m_po[i] : m_pe[i]) | (va & (m >> 1));
                    rd = 1;
                    wr = f[1];
                end
                return;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_vpn[i] = 0; m_pm[i] = 0; m_pe[i] = 0; m_po[i] = 0; m_asid[i] = 0;
                m_g[i] = 0; m_hinv[i] = 1; m_fe[i] = 0; m_fo[i] = 0;
            end
            e_vld = 0; e_code = -2; e_pa = 0; e_rd = 0; e_wr = 0; e_tag = "R1";
        end else begin
            e_vld = req_valid;
            e_tag = req_valid ? cur_tag : "R8";
            if (req_valid) ref_lookup(req_vaddr, int'(req_kind), int'(req_asid),
                                      e_code, e_pa, e_rd, e_wr);
            if (wr_en) begin
                m_vpn[wr_idx] = wr_vpn; m_pm[wr_idx] = wr_pmask; m_asid[wr_idx] = int'(wr_asid);
                m_g[wr_idx] = wr_global; m_hinv[wr_idx] = wr_hinv;
                m_pe[wr_idx] = wr_pfn_even; m_po[wr_idx] = wr_pfn_odd;
                m_fe[wr_idx] = wr_flags_even; m_fo[wr_idx] = wr_flags_odd;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (rsp_valid !== e_vld || rsp_code != 4'(e_code) || rsp_paddr !== e_pa ||
                rsp_read_ok !== e_rd || rsp_write_ok !== e_wr) begin
                fails++;
                $display("FAIL %s: act vld=%0b code=%0d pa=%h rd=%0b wr=%0b exp vld=%0b code=%0d pa=%h rd=%0b wr=%0b",
                         e_tag, rsp_valid, rsp_code, rsp_paddr, rsp_read_ok, rsp_write_ok,
                         e_vld, e_code, e_pa, e_rd, e_wr);
            end
        end
    end

    task automatic lk(input logic [31:0] va, input int kind, input int asid, input string tag);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = kind[1:0]; req_asid = asid[7:0];
        wr_en = 0; cur_tag = tag;
    endtask

    task automatic wr(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                      input int asid, input bit g, input bit hv, input logic [31:0] pe,
                      input logic [31:0] po, input logic [3:0] fe, input logic [3:0] fo,
                      input bit with_lookup);
        @(negedge clk);
        wr_en = 1; wr_idx = idx[3:0]; wr_vpn = vpn; wr_pmask = pm; wr_asid = asid[7:0];
        wr_global = g; wr_hinv = hv; wr_pfn_even = pe; wr_pfn_odd = po;
        wr_flags_even = fe; wr_flags_odd = fo;
        req_valid = with_lookup;
        if (with_lookup) begin
            req_vaddr = vpn; req_kind = 2'd1; req_asid = 8'd5; cur_tag = "R9";
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 0; wr_en = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        lk(32'h0040_0123, 1, 5, "R1");                  // empty table misses
        // even page dirty, odd page clean, 4 KB pages
        wr(0, 32'h0040_0000, 0, 5, 0, 0, 32'h1000_0000, 32'h2000_0000, 4'b0011, 4'b0001, 0);
        lk(32'h0040_0123, 1, 5, "R4");
        lk(32'h0040_0123, 2, 5, "R6");
        lk(32'h0040_1456, 2, 5, "R5");                  // store to clean page
        lk(32'h0040_1456, 1, 5, "R6");
        lk(32'h0040_0123, 1, 6, "R2");                  // other address space
        // global 64 KB pair
        wr(1, 32'h0080_0000, 32'h0001_E000, 0, 1, 0, 32'h3000_0000, 32'h4000_0000, 4'b0011, 4'b0011, 0);
        lk(32'h0081_2345, 0, 9, "R3");
        lk(32'h0080_ABCD, 2, 9, "R3");
        // inhibit bits
        wr(2, 32'h0100_0000, 0, 5, 0, 0, 32'h5100_0000, 32'h5200_0000, 4'b1001, 4'b0111, 0);
        lk(32'h0100_0010, 0, 5, "R5");
        lk(32'h0100_0010, 1, 5, "R5");
        lk(32'h0100_1010, 1, 5, "R5");
        lk(32'h0100_1010, 0, 5, "R5");
        lk(32'h0100_1010, 2, 5, "R5");
        // invalid page with execute-inhibit: invalid wins
        wr(3, 32'h0200_0000, 0, 5, 0, 0, 32'h5300_0000, 32'h5400_0000, 4'b1000, 4'b0000, 0);
        lk(32'h0200_0004, 0, 5, "R5");
        // invalidated entry never matches
        wr(4, 32'h0300_0000, 0, 0, 1, 1, 32'h5500_0000, 32'h5600_0000, 4'b0011, 4'b0011, 0);
        lk(32'h0300_0004, 1, 5, "R2");
        // overlapping entries: lowest index wins
        wr(6, 32'h0400_0000, 0, 0, 1, 0, 32'h5000_0000, 32'h5800_0000, 4'b0011, 4'b0011, 0);
        wr(5, 32'h0400_0000, 32'h0000_6000, 0, 1, 0, 32'h6000_0000, 32'h6800_0000, 4'b0011, 4'b0011, 0);
        lk(32'h0400_0010, 1, 5, "R7");
        wr(5, 32'h0400_0000, 32'h0000_6000, 0, 1, 1, 32'h6000_0000, 32'h6800_0000, 4'b0011, 4'b0011, 0);
        lk(32'h0400_0010, 1, 5, "R7");
        idle(3);                                        // outputs hold
        // write and lookup together: old contents seen
        wr(8, 32'h0500_0000, 0, 0, 1, 0, 32'h7000_0000, 32'h7100_0000, 4'b0011, 4'b0011, 1);
        lk(32'h0500_0000, 1, 5, "R9");
        idle(2);
        // mixed random traffic
        for (int k = 0; k < 600; k++) begin
            int sel = $urandom_range(0, 9);
            logic [31:0] base = 32'h0040_0000 << $urandom_range(0, 6);
            if (sel == 0) begin
                logic [31:0] pm = ($urandom_range(0, 2) == 0) ? 32'h0 :
                                  (($urandom_range(0, 1) == 0) ? 32'h6000 : 32'h1E000);
                wr($urandom_range(0, 15), base, pm, $urandom_range(5, 7),
                   1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
                   32'($urandom) & 32'hFFFE_0000, 32'($urandom) & 32'hFFFE_0000,
                   4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 0);
            end else if (sel == 1) begin
                idle(1);
            end else begin
                lk(base | (32'($urandom) & 32'h0001_FFFF), $urandom_range(0, 2),
                   $urandom_range(5, 7), "R5");
            end
        end
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: act running exp finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule